// File: doc/BRIEF.md
# Prioritised Outbound Address Window Translator

This block turns a 32-bit local-bus address into a PCI bus address, a PCI cycle type and a flag that says whether the low two address bits come from the host. It has three programmable window pairs. Each pair has a base register and a map register. Windows 0 and 1 are memory windows with a selectable size from 1 MB to 2 GB. Window 2 is an I/O window that decodes on a 16 MB granule.

Software programs the six window registers through a simple synchronous write port and reads them back through a combinational read port. A lookup port is purely combinational. When several enabled windows claim the same address, the lowest-numbered one supplies the translation.

This priority lets software enlarge window 0 over window 1. While window 0 covers that range, window 1 can be retargeted, for example to configuration space, without disturbing any address in the overlap.

Top module: `xw_xlate_top`

## Requirements
- R1: After reset every window register reads zero and no lookup address produces a hit.
- R2: Register select codes are 0 = window-0 base, 1 = window-0 map, 2 = window-1 base, 3 = window-1 map, 4 = I/O base and 5 = I/O map. A write lands on the clock edge while the write enable is high. Reads are combinational. A memory base keeps bits 31:20, 9:8, 7:4, 3 and 0. A memory map keeps bits 15:0. The I/O base keeps bits 15:8 and 0. The I/O map keeps bits 15:8. Every other bit reads zero. Select codes 6 and 7 read zero, and writes to them change nothing.
- R3: A memory window matches when its enable (base bit 0) is set and the address bits at and above bit 20+size equal the same bits of the base. The size code sits in base bits 7:4 and gives a window of 2^(20+size) bytes.
- R4: On a memory hit, the translated address takes map bits 15:4 as PCI bits 31:20 for every bit above the window size. All offset bits below the window size pass through unchanged.
- R5: On a memory hit, the cycle type output equals map bits 3:1 and the low-bits flag equals map bit 0. The type codes are 0 interrupt acknowledge, 1 I/O, 3 memory, 5 configuration and 6 memory-multiple.
- R6: The I/O window matches when I/O base bit 0 is set and address bits 31:24 equal I/O base bits 15:8. On a hit it yields window index 2, PCI bits 31:24 from I/O map bits 15:8, address bits 23:0 unchanged, type 1 and a low-bits flag of 0.
- R7: When more than one enabled window matches, the lowest window index wins.
- R8: Size codes 12 to 15 make a memory window match nothing.
- R9: On a miss, hit, window index, address, type and low-bits flag are all zero.
- R10: The prefetch bit (base bit 3) and the swap field (base bits 9:8) are stored but have no effect on lookups.
- R11: When window 0 grows from 256 MB to 512 MB over an adjacent window 1, addresses in window 1's range translate through window 0, and reprogramming window 1 leaves them unchanged. After window 0 shrinks back, window 1's new setting takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 32 | Read data |
| lk_addr | input | 32 | Local address to translate |
| lk_hit | output | 1 | Some enabled window matches |
| lk_win | output | 2 | Index of the winning window |
| lk_pci_addr | output | 32 | Translated PCI address |
| lk_type | output | 3 | PCI cycle type |
| lk_low_en | output | 1 | Low address bits taken from host |

## Verification
The hardest state to reach is the one where two windows overlap and the lower one hides the upper one. In that state, reprogramming the hidden window must have no visible effect. The only way to observe this from the ports is to look up an address in the shared range before and after rewriting window 1 while window 0 covers it, then shrink window 0 and show the new window 1 translation appear.

The bench therefore runs that exact sequence of register writes. It also probes the extreme size codes 0, 11 and 12 at addresses just inside and just outside each window edge.

// File: rtl/xw_pkg.sv
`timescale 1ns/1ps
package xw_pkg;
    localparam int ADDR_W   = 32;
    localparam int MAP_W    = 16;
    localparam int BLK_LSB  = 20;
    localparam int BLK_W    = ADDR_W - BLK_LSB;
    localparam int SZ_W     = 4;
    localparam int MAX_SZ   = 11;
    localparam int TYPE_W   = 3;
    localparam int IO_LSB   = 24;
    localparam int IO_W     = ADDR_W - IO_LSB;
    localparam int NUM_MEM  = 2;
    localparam int NUM_WIN  = NUM_MEM + 1;
    localparam int WIN_W    = $clog2(NUM_WIN);
    localparam int NUM_REG  = 2 * NUM_WIN;
    localparam int SEL_W    = $clog2(NUM_REG + 2);

    localparam logic [ADDR_W-1:0] MBASE_KEEP  = 32'hFFF0_03F9;
    localparam logic [MAP_W-1:0]  IOBASE_KEEP = 16'hFF01;
    localparam logic [MAP_W-1:0]  IOMAP_KEEP  = 16'hFF00;

    localparam logic [TYPE_W-1:0] CT_IO = 3'd1;

    typedef struct packed {
        logic [NUM_MEM-1:0][ADDR_W-1:0] mbase;
        logic [NUM_MEM-1:0][MAP_W-1:0]  mmap;
        logic [MAP_W-1:0]               iobase;
        logic [MAP_W-1:0]               iomap;
    } win_regs_t;

    typedef struct packed {
        logic              hit;
        logic [WIN_W-1:0]  win;
        logic [ADDR_W-1:0] pci;
        logic [TYPE_W-1:0] ctype;
        logic              low_en;
    } xlat_t;
endpackage

// File: rtl/xw_regs.sv
`timescale 1ns/1ps
module xw_regs
    import xw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [ADDR_W-1:0]     wr_data,
    input  logic [SEL_W-1:0]      rd_sel,
    output logic [ADDR_W-1:0]     rd_data,
    output win_regs_t             regs
);
    win_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            for (int i = 0; i < NUM_MEM; i++) begin
                if (wr_sel == SEL_W'(2*i))
                    regs_d.mbase[i] = wr_data & MBASE_KEEP;
                if (wr_sel == SEL_W'(2*i+1))
                    regs_d.mmap[i] = wr_data[MAP_W-1:0];
            end
            if (wr_sel == SEL_W'(2*NUM_MEM))
                regs_d.iobase = wr_data[MAP_W-1:0] & IOBASE_KEEP;
            if (wr_sel == SEL_W'(2*NUM_MEM+1))
                regs_d.iomap = wr_data[MAP_W-1:0] & IOMAP_KEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_MEM; i++) begin
            if (rd_sel == SEL_W'(2*i))   rd_data = regs_q.mbase[i];
            if (rd_sel == SEL_W'(2*i+1)) rd_data = {{(ADDR_W-MAP_W){1'b0}}, regs_q.mmap[i]};
        end
        if (rd_sel == SEL_W'(2*NUM_MEM))   rd_data = {{(ADDR_W-MAP_W){1'b0}}, regs_q.iobase};
        if (rd_sel == SEL_W'(2*NUM_MEM+1)) rd_data = {{(ADDR_W-MAP_W){1'b0}}, regs_q.iomap};
    end

    assign regs = regs_q;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q)); // R2
    AST_BAD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel >= SEL_W'(NUM_REG)) |=> $stable(regs_q)); // R2
endmodule

// File: rtl/xw_mem_match.sv
`timescale 1ns/1ps
module xw_mem_match
    import xw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BLK_W-1:0]   base_hi,
    input  logic [SZ_W-1:0]    size,
    input  logic               en,
    input  logic [MAP_W-1:0]   map,
    output logic               hit,
    output logic [ADDR_W-1:0]  pci,
    output logic [TYPE_W-1:0]  ctype,
    output logic               low_en
);
    logic [ADDR_W-1:0] hi_mask;
    logic [ADDR_W-1:0] base_full;
    logic [ADDR_W-1:0] map_full;
    logic              size_ok;

    always_comb begin
        size_ok   = (size <= SZ_W'(MAX_SZ));
        hi_mask   = size_ok ? ({ADDR_W{1'b1}} << (BLK_LSB + int'(size))) : '0;
        base_full = {base_hi, {BLK_LSB{1'b0}}};
        map_full  = {map[MAP_W-1:MAP_W-BLK_W], {BLK_LSB{1'b0}}};
        hit       = en && size_ok && (((addr ^ base_full) & hi_mask) == '0);
        pci       = hit ? ((map_full & hi_mask) | (addr & ~hi_mask)) : '0;
        ctype     = hit ? map[3:1] : '0;
        low_en    = hit ? map[0] : 1'b0;
    end

    AST_MEM_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pci[BLK_LSB-1:0] == addr[BLK_LSB-1:0])); // R4
    AST_MEM_BIGSIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (size > SZ_W'(MAX_SZ)) |-> !hit); // R8
endmodule

// File: rtl/xw_io_match.sv
`timescale 1ns/1ps
module xw_io_match
    import xw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [IO_W-1:0]    base_hi,
    input  logic               en,
    input  logic [IO_W-1:0]    map_hi,
    output logic               hit,
    output logic [ADDR_W-1:0]  pci
);
    always_comb begin
        hit = en && (addr[ADDR_W-1:IO_LSB] == base_hi);
        pci = hit ? {map_hi, addr[IO_LSB-1:0]} : '0;
    end

    AST_IO_TOPBITS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pci[ADDR_W-1:IO_LSB] == map_hi)); // R6
endmodule

// File: rtl/xw_xlate_top.sv
`timescale 1ns/1ps
module xw_xlate_top
    import xw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [31:0]        wr_data,
    input  logic [2:0]         rd_sel,
    output logic [31:0]        rd_data,
    input  logic [31:0]        lk_addr,
    output logic               lk_hit,
    output logic [1:0]         lk_win,
    output logic [31:0]        lk_pci_addr,
    output logic [2:0]         lk_type,
    output logic               lk_low_en
);
    win_regs_t regs;

    xw_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .regs    (regs)
    );

    logic [NUM_MEM-1:0]              mem_hit;
    logic [NUM_MEM-1:0][ADDR_W-1:0]  mem_pci;
    logic [NUM_MEM-1:0][TYPE_W-1:0]  mem_type;
    logic [NUM_MEM-1:0]              mem_low;

    for (genvar g = 0; g < NUM_MEM; g++) begin : g_mem
        xw_mem_match u_mm (
            .clk     (clk),
            .rst_n   (rst_n),
            .addr    (lk_addr),
            .base_hi (regs.mbase[g][ADDR_W-1:BLK_LSB]),
            .size    (regs.mbase[g][7:4]),
            .en      (regs.mbase[g][0]),
            .map     (regs.mmap[g]),
            .hit     (mem_hit[g]),
            .pci     (mem_pci[g]),
            .ctype   (mem_type[g]),
            .low_en  (mem_low[g])
        );
    end

    logic              io_hit;
    logic [ADDR_W-1:0] io_pci;

    xw_io_match u_io (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (lk_addr),
        .base_hi (regs.iobase[MAP_W-1:MAP_W-IO_W]),
        .en      (regs.iobase[0]),
        .map_hi  (regs.iomap[MAP_W-1:MAP_W-IO_W]),
        .hit     (io_hit),
        .pci     (io_pci)
    );

    xlat_t res;

    always_comb begin
        res = '0;
        if (io_hit) begin
            res.hit   = 1'b1;
            res.win   = WIN_W'(NUM_MEM);
            res.pci   = io_pci;
            res.ctype = CT_IO;
        end
        for (int i = NUM_MEM - 1; i >= 0; i--) begin
            if (mem_hit[i]) begin
                res.hit    = 1'b1;
                res.win    = WIN_W'(i);
                res.pci    = mem_pci[i];
                res.ctype  = mem_type[i];
                res.low_en = mem_low[i];
            end
        end
    end

    assign lk_hit      = res.hit;
    assign lk_win      = res.win;
    assign lk_pci_addr = res.pci;
    assign lk_type     = res.ctype;
    assign lk_low_en   = res.low_en;

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_win != 2'd0) |-> !mem_hit[0]); // R7
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pci_addr == '0 && lk_type == '0 && lk_win == '0 && !lk_low_en)); // R9
    AST_IO_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_win == 2'd2) |-> (lk_type == 3'd1 && !lk_low_en
                                         && lk_pci_addr[23:0] == lk_addr[23:0])); // R6
    AST_WIN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_win <= 2'd2)); // R7
endmodule

// File: tb/sim_xw_xlate_top.sv
`timescale 1ns/1ps
module sim_xw_xlate_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic [31:0] lk_addr = '0;
    logic        lk_hit;
    logic [1:0]  lk_win;
    logic [31:0] lk_pci_addr;
    logic [2:0]  lk_type;
    logic        lk_low_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    xw_xlate_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_win(lk_win),
        .lk_pci_addr(lk_pci_addr), .lk_type(lk_type), .lk_low_en(lk_low_en)
    );

    // {addr, hit, win, pci, type, low}
    localparam int NV = 8;
    localparam logic [70:0] VEC [NV] = '{
        {32'h4123_4567, 1'b1, 2'd0, 32'h8123_4567, 3'd3, 1'b0},
        {32'h4FFF_FFFF, 1'b1, 2'd0, 32'h8FFF_FFFF, 3'd3, 1'b0},
        {32'h5ABC_DEF0, 1'b1, 2'd1, 32'h1ABC_DEF0, 3'd5, 1'b1},
        {32'h6012_3456, 1'b1, 2'd2, 32'hAB12_3456, 3'd1, 1'b0},
        {32'h60FF_FFFF, 1'b1, 2'd2, 32'hABFF_FFFF, 3'd1, 1'b0},
        {32'h6100_0000, 1'b0, 2'd0, 32'h0,         3'd0, 1'b0},
        {32'h3FFF_FFFF, 1'b0, 2'd0, 32'h0,         3'd0, 1'b0},
        {32'hFFFF_FFFF, 1'b0, 2'd0, 32'h0,         3'd0, 1'b0}
    };

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_rd(input logic [2:0] s, input logic [31:0] exp, input string req);
        @(negedge clk);
        rd_sel = s;
        #1;
        n_chk++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s read sel=%0d actual=%h expected=%h", req, s, rd_data, exp);
        end
    endtask

    task automatic look(input logic [31:0] a, input logic eh, input logic [1:0] ew,
                        input logic [31:0] ep, input logic [2:0] et, input logic el,
                        input string req);
        @(negedge clk);
        lk_addr = a;
        #1;
        n_chk++;
        if (lk_hit !== eh || lk_win !== ew || lk_pci_addr !== ep ||
            lk_type !== et || lk_low_en !== el) begin
            n_bad++;
            $display("FAIL %s addr=%h actual=%b/%0d/%h/%0d/%b expected=%b/%0d/%h/%0d/%b",
                     req, a, lk_hit, lk_win, lk_pci_addr, lk_type, lk_low_en,
                     eh, ew, ep, et, el);
        end
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int s = 0; s < 6; s++) chk_rd(3'(s), 32'h0, "R1");
        look(32'h0000_0000, 1'b0, 2'd0, 32'h0, 3'd0, 1'b0, "R1");

        // R2: field masking and unused selects
        wr(3'd0, 32'hFFFF_FFFF); chk_rd(3'd0, 32'hFFF0_03F9, "R2");
        wr(3'd1, 32'hFFFF_FFFF); chk_rd(3'd1, 32'h0000_FFFF, "R2");
        wr(3'd4, 32'hFFFF_FFFF); chk_rd(3'd4, 32'h0000_FF01, "R2");
        wr(3'd5, 32'hFFFF_FFFF); chk_rd(3'd5, 32'h0000_FF00, "R2");
        wr(3'd6, 32'hFFFF_FFFF); chk_rd(3'd6, 32'h0, "R2");
        chk_rd(3'd2, 32'h0, "R2 sel6 write left window-1 base alone");

        // Table configuration
        wr(3'd0, 32'h4000_0081); wr(3'd1, 32'h0000_8006);
        wr(3'd2, 32'h5000_0089); wr(3'd3, 32'h0000_100B);
        wr(3'd4, 32'h0000_6001); wr(3'd5, 32'h0000_AB00);
        for (int i = 0; i < NV; i++) begin
            logic [70:0] v;
            v = VEC[i];
            look(v[70:39], v[38], v[37:36], v[35:4], v[3:1], v[0], "R3 R4 R5 R6 R9 table");
        end

        // R10: prefetch and swap bits change nothing
        wr(3'd0, 32'h4000_0389);
        chk_rd(3'd0, 32'h4000_0389, "R10 readback");
        look(32'h4123_4567, 1'b1, 2'd0, 32'h8123_4567, 3'd3, 1'b0, "R10");
        wr(3'd0, 32'h4000_0081);

        // R11: grow window 0 over window 1, retarget window 1, shrink back
        wr(3'd0, 32'h4000_0091);
        look(32'h5ABC_DEF0, 1'b1, 2'd0, 32'h9ABC_DEF0, 3'd3, 1'b0, "R7 R11 overlap");
        wr(3'd2, 32'h5000_0081); wr(3'd3, 32'h0000_200A);
        look(32'h5ABC_DEF0, 1'b1, 2'd0, 32'h9ABC_DEF0, 3'd3, 1'b0, "R11 hidden reprogram");
        wr(3'd0, 32'h4000_0081);
        look(32'h5ABC_DEF0, 1'b1, 2'd1, 32'h2ABC_DEF0, 3'd5, 1'b0, "R11 revealed");

        // R8: size code 12 disables window 0
        wr(3'd0, 32'h4000_00C1);
        look(32'h4123_4567, 1'b0, 2'd0, 32'h0, 3'd0, 1'b0, "R8");

        // R3 R4: largest size (2 GB) at base 0
        wr(3'd0, 32'h0000_00B1);
        look(32'h7FFF_FFFF, 1'b1, 2'd0, 32'hFFFF_FFFF, 3'd3, 1'b0, "R4 2GB");
        look(32'h8000_0000, 1'b0, 2'd0, 32'h0, 3'd0, 1'b0, "R3 2GB edge");

        // R3: smallest size (1 MB)
        wr(3'd0, 32'h4000_0001);
        look(32'h400F_FFFF, 1'b1, 2'd0, 32'h800F_FFFF, 3'd3, 1'b0, "R3 1MB in");
        look(32'h4010_0000, 1'b0, 2'd0, 32'h0, 3'd0, 1'b0, "R3 1MB out");

        // R6: I/O window disabled by base bit 0
        wr(3'd4, 32'h0000_6000);
        look(32'h6012_3456, 1'b0, 2'd0, 32'h0, 3'd0, 1'b0, "R6 disabled");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule